// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register Block

This block collects event pulses from a multi-channel DMA engine into two interrupt groups, one for normal events and one for error events, and turns them into a single level-sensitive interrupt line. Each group has a status register and a mask register. A one-cycle pulse on an event input bit latches the matching status bit. Software clears status bits by writing ones to them. The masks cannot be written directly. A pair of dedicated addresses per group clears mask bits (unmask) or sets them (mask).

The same 32-bit, word-aligned register port also holds the per-channel configuration words that sit next to the interrupt registers. These are a control word, a descriptor start address and its upper extension. It also holds a global command register that can only be written, and a set of per-channel status, size and identifier addresses that are read-only and read as zero here. Reads are combinational on `reg_addr`. Writes take effect on the rising clock edge where `reg_wr` is high.

Address map (byte offsets):
- 0x00 normal status
- 0x04 normal mask
- 0x08 normal unmask
- 0x0C normal mask-set
- 0x10 error status
- 0x14 error mask
- 0x18 error unmask
- 0x1C error mask-set
- 0x20 global command

Channel `c` starts at 0x100 + 0x40·c. Within that block, the offsets are:
- +0x00 control
- +0x04 start address
- +0x08 start address extension
- +0x0C status
- +0x10 payload size
- +0x14 descriptor id

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, the normal mask reads 0x07FFFFFF and the error mask reads 0xFFFFFFFF. Both status registers, all channel registers and `gcmd_o` read zero, and `irq_o` is low.
- R2: A high bit on `evt_norm_i` or `evt_err_i` in a cycle sets the same bit of the normal or error status register at that clock edge. The bit then stays set until software clears it.
- R3: Writing to a status address clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to an unmask address (0x08, 0x18) clears each mask bit written as 1. A write to a mask-set address (0x0C, 0x1C) sets each mask bit written as 1. Other mask bits are kept.
- R5: Writes to the mask addresses (0x04, 0x14) and to the channel status, size and id offsets change nothing. Those channel offsets always read zero.
- R6: `irq_o` is high exactly when, on the previous clock edge, some status bit had its mask bit clear in either group. It is a register output, so it follows any status or mask change by one cycle.
- R7: A write to the global command address (0x20) keeps the low 12 bits, which appear on `gcmd_o`. A read of that address always returns zero.
- R8: Writing a channel control word keeps bits 29:0 only. Writing the start address extension keeps bits 15:0 only. The start address keeps all 32 bits. Each channel's words are independent of the other channels.
- R9: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A write whose address has bit 1 or bit 0 set changes no register. A read at such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_norm_i | input | 32 | Normal event pulses, one bit per event source |
| evt_err_i | input | 32 | Error event pulses, one bit per event source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| gcmd_o | output | 12 | Held value of the global command register |
| irq_o | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle against the status and mask registers:
- an event bit always lands in status (R2);
- a set beats a clear in the same cycle (R9);
- a status write clears exactly the written ones (R3);
- the mask addresses and misaligned writes leave state untouched (R5, R10);
- the interrupt line equals the previous cycle's unmasked pending term (R6);
- the command address always reads zero (R7).

Other behaviours are only shown by the directed scenarios:
- the reset values;
- the exact mask arithmetic of the unmask and mask-set addresses;
- the field truncation of channel words;
- the isolation between channels;
- the one-cycle interrupt latency seen as a sequence, for an event in bit 27 that the reset mask leaves open.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // Global register byte offsets
  localparam int OFF_NSTAT = 'h00;
  localparam int OFF_NMASK = 'h04;
  localparam int OFF_NEN   = 'h08;
  localparam int OFF_NDIS  = 'h0C;
  localparam int OFF_ESTAT = 'h10;
  localparam int OFF_EMASK = 'h14;
  localparam int OFF_EEN   = 'h18;
  localparam int OFF_EDIS  = 'h1C;
  localparam int OFF_GCMD  = 'h20;

  // Channel blocks: block index = addr >> CH_SHIFT, first channel at CH_BASE_BLK
  localparam int CH_SHIFT    = 6;
  localparam int CH_BASE_BLK = 4;

  // Offsets inside a channel block
  localparam int CH_CTRL   = 'h00;
  localparam int CH_START  = 'h04;
  localparam int CH_EXT    = 'h08;
  localparam int CH_STATUS = 'h0C;
  localparam int CH_SIZE   = 'h10;
  localparam int CH_ID     = 'h14;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int            W        = 32,
  parameter logic [W-1:0]  MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we,
  input  logic         unmask_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] mask_q, mask_d;
  logic         stat_en, mask_en;

  always_comb begin
    stat_en = clr_we | (|evt_i);
    stat_d  = stat_q;
    if (clr_we) stat_d = stat_d & ~wdata;
    // event is applied last so a coincident clear never loses it
    stat_d  = stat_d | evt_i;

    mask_en = unmask_we | mask_we;
    mask_d  = mask_q;
    if (unmask_we) mask_d = mask_q & ~wdata;
    if (mask_we)   mask_d = mask_q | wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/chan_cfg.sv
module chan_cfg #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 30,
  parameter int EXT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              start_we,
  input  logic              ext_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] start_o,
  output logic [EXT_W-1:0]  ext_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] start_q;
  logic [EXT_W-1:0]  ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
      ext_q   <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= wdata[CTRL_W-1:0];
      if (start_we) start_q <= wdata;
      if (ext_we)   ext_q   <= wdata[EXT_W-1:0];
    end
  end

  assign ctrl_o  = ctrl_q;
  assign start_o = start_q;
  assign ext_o   = ext_q;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dmairq_pkg::*;
#(
  parameter int               NCH       = 6,
  parameter int               ADDR_W    = 12,
  parameter int               DATA_W    = 32,
  parameter int               GCMD_W    = 12,
  parameter int               CTRL_W    = 30,
  parameter int               EXT_W     = 16,
  parameter logic [DATA_W-1:0] NMASK_RST = 32'h07FF_FFFF,
  parameter logic [DATA_W-1:0] EMASK_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_norm_i,
  input  logic [DATA_W-1:0] evt_err_i,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [GCMD_W-1:0] gcmd_o,
  output logic              irq_o
);
  localparam int BLK_W = ADDR_W - CH_SHIFT;

  logic              aligned, wr_ok;
  logic [DATA_W-1:0] nstat_w, nmask_w, estat_w, emask_w;
  logic              npend_w, epend_w;
  logic [GCMD_W-1:0] gcmd_q, gcmd_d;
  logic              gcmd_en;
  logic              irq_q, irq_d;
  logic [BLK_W-1:0]  blk;
  logic [CH_SHIFT-1:0] sub;

  logic [CTRL_W-1:0] ch_ctrl  [NCH];
  logic [DATA_W-1:0] ch_start [NCH];
  logic [EXT_W-1:0]  ch_ext   [NCH];

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign wr_ok   = reg_wr & aligned;
  assign blk     = reg_addr[ADDR_W-1:CH_SHIFT];
  assign sub     = reg_addr[CH_SHIFT-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  irq_group #(.W(DATA_W), .MASK_RST(NMASK_RST)) u_norm (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_norm_i),
    .clr_we(wr_ok & hit(reg_addr, OFF_NSTAT)),
    .unmask_we(wr_ok & hit(reg_addr, OFF_NEN)),
    .mask_we(wr_ok & hit(reg_addr, OFF_NDIS)),
    .wdata(reg_wdata), .stat_o(nstat_w), .mask_o(nmask_w), .pend_o(npend_w)
  );

  irq_group #(.W(DATA_W), .MASK_RST(EMASK_RST)) u_err (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_err_i),
    .clr_we(wr_ok & hit(reg_addr, OFF_ESTAT)),
    .unmask_we(wr_ok & hit(reg_addr, OFF_EEN)),
    .mask_we(wr_ok & hit(reg_addr, OFF_EDIS)),
    .wdata(reg_wdata), .stat_o(estat_w), .mask_o(emask_w), .pend_o(epend_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = wr_ok & (blk == BLK_W'(CH_BASE_BLK + c));
    chan_cfg #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .EXT_W(EXT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(sel & (sub == CH_SHIFT'(CH_CTRL))),
      .start_we(sel & (sub == CH_SHIFT'(CH_START))),
      .ext_we(sel & (sub == CH_SHIFT'(CH_EXT))),
      .wdata(reg_wdata),
      .ctrl_o(ch_ctrl[c]), .start_o(ch_start[c]), .ext_o(ch_ext[c])
    );
  end

  // Global command and interrupt: next-state
  always_comb begin
    gcmd_en = wr_ok & hit(reg_addr, OFF_GCMD);
    gcmd_d  = reg_wdata[GCMD_W-1:0];
    irq_d   = npend_w | epend_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcmd_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (gcmd_en) gcmd_q <= gcmd_d;
      irq_q <= irq_d;
    end
  end

  // Read mux; command, status/size/id and misaligned addresses read zero
  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (hit(reg_addr, OFF_NSTAT)) reg_rdata = nstat_w;
      if (hit(reg_addr, OFF_NMASK)) reg_rdata = nmask_w;
      if (hit(reg_addr, OFF_ESTAT)) reg_rdata = estat_w;
      if (hit(reg_addr, OFF_EMASK)) reg_rdata = emask_w;
      for (int c = 0; c < NCH; c++) begin
        if (blk == BLK_W'(CH_BASE_BLK + c)) begin
          if (sub == CH_SHIFT'(CH_CTRL))  reg_rdata = DATA_W'(ch_ctrl[c]);
          if (sub == CH_SHIFT'(CH_START)) reg_rdata = ch_start[c];
          if (sub == CH_SHIFT'(CH_EXT))   reg_rdata = DATA_W'(ch_ext[c]);
        end
      end
    end
  end

  assign gcmd_o = gcmd_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] evt_n,
  input logic [DATA_W-1:0] evt_e,
  input logic [DATA_W-1:0] nstat,
  input logic [DATA_W-1:0] nmask,
  input logic [DATA_W-1:0] estat,
  input logic [DATA_W-1:0] emask,
  input logic              irq
);
  logic al_wr;
  assign al_wr = reg_wr && (reg_addr[1:0] == 2'b00);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_n != '0 || evt_e != '0) |=>
      ((nstat & $past(evt_n)) == $past(evt_n)) && ((estat & $past(evt_e)) == $past(evt_e)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (al_wr && reg_addr == ADDR_W'('h00) && evt_n == '0) |=> ((nstat & $past(reg_wdata)) == '0));

  assert_mask_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (al_wr && (reg_addr == ADDR_W'('h04) || reg_addr == ADDR_W'('h14))) |=>
      ($stable(nmask) && $stable(emask)));

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past((|(nstat & ~nmask)) || (|(estat & ~emask)))));

  assert_gcmd_rz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'('h20)) |-> (reg_rdata == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (al_wr && reg_addr == ADDR_W'('h00) && (reg_wdata & evt_n) != '0) |=>
      ((nstat & $past(reg_wdata & evt_n)) == $past(reg_wdata & evt_n)));

  assert_unaligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[1:0] != 2'b00 && evt_n == '0 && evt_e == '0) |=>
      ($stable(nstat) && $stable(nmask) && $stable(estat) && $stable(emask)));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_n(evt_norm_i), .evt_e(evt_err_i),
  .nstat(nstat_w), .nmask(nmask_w), .estat(estat_w), .emask(emask_w), .irq(irq_o)
);

// File: tb/dma_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dma_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_norm_i, evt_err_i;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [11:0] gcmd_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dma_irq_ctrl u_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_norm_i(evt_norm_i), .evt_err_i(evt_err_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .gcmd_o(gcmd_o), .irq_o(irq_o)
  );

  localparam logic [11:0] A_NSTAT = 12'h00, A_NMASK = 12'h04, A_NEN = 12'h08, A_NDIS = 12'h0C;
  localparam logic [11:0] A_ESTAT = 12'h10, A_EMASK = 12'h14, A_EEN = 12'h18, A_EDIS = 12'h1C;
  localparam logic [11:0] A_GCMD  = 12'h20;

  function automatic logic [11:0] cha(input int ch, input int off);
    return 12'(12'h100 + ch * 12'h40 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] n, input logic [31:0] e);
    @(negedge clk);
    evt_norm_i = n; evt_err_i = e;
    @(negedge clk);
    evt_norm_i = '0; evt_err_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_NMASK, v); chk("R1 nmask", v, 32'h07FF_FFFF);
    rd(A_EMASK, v); chk("R1 emask", v, 32'hFFFF_FFFF);
    rd(A_NSTAT, v); chk("R1 nstat", v, 0);
    rd(A_ESTAT, v); chk("R1 estat", v, 0);
    rd(cha(4, 0), v); chk("R1 ch ctrl", v, 0);
    chk("R1 gcmd", 32'(gcmd_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(32'h0000_0105, 32'h8000_0002);
    @(negedge clk);
    rd(A_NSTAT, v); chk("R2 nstat held", v, 32'h0000_0105);
    rd(A_ESTAT, v); chk("R2 estat held", v, 32'h8000_0002);
    chk("R2 masked no irq", 32'(irq_o), 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_NSTAT, 32'h0000_0004);
    rd(A_NSTAT, v); chk("R3 nstat partial", v, 32'h0000_0101);
    wr(A_ESTAT, 32'h8000_0000);
    rd(A_ESTAT, v); chk("R3 estat partial", v, 32'h0000_0002);
    wr(A_NSTAT, 32'hFFFF_FFFF); wr(A_ESTAT, 32'hFFFF_FFFF);
    rd(A_NSTAT, v); chk("R3 nstat all", v, 0);
    rd(A_ESTAT, v); chk("R3 estat all", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_NEN, 32'h0000_00F0);
    rd(A_NMASK, v); chk("R4 unmask", v, 32'h07FF_FF0F);
    wr(A_NDIS, 32'h0000_0030);
    rd(A_NMASK, v); chk("R4 mask-set", v, 32'h07FF_FF3F);
    wr(A_EEN, 32'h0000_0001);
    rd(A_EMASK, v); chk("R4 err unmask", v, 32'hFFFF_FFFE);
    wr(A_EDIS, 32'h0000_0001);
    rd(A_EMASK, v); chk("R4 err mask-set", v, 32'hFFFF_FFFF);
    wr(A_NDIS, 32'h0000_00C0);
    rd(A_NMASK, v); chk("R4 restore", v, 32'h07FF_FFFF);
  endtask

  task automatic t_ro();
    logic [31:0] v;
    wr(A_NMASK, 32'h0); wr(A_EMASK, 32'h0);
    rd(A_NMASK, v); chk("R5 nmask direct", v, 32'h07FF_FFFF);
    rd(A_EMASK, v); chk("R5 emask direct", v, 32'hFFFF_FFFF);
    wr(cha(2, 'h0C), 32'hFFFF_FFFF); wr(cha(2, 'h10), 32'hFFFF_FFFF); wr(cha(2, 'h14), 32'hFFFF_FFFF);
    rd(cha(2, 'h0C), v); chk("R5 ch status", v, 0);
    rd(cha(2, 'h10), v); chk("R5 ch size", v, 0);
    rd(cha(2, 'h14), v); chk("R5 ch id", v, 0);
    rd(cha(2, 0), v); chk("R5 ch ctrl untouched", v, 0);
    chk("R5 irq", 32'(irq_o), 0);
  endtask

  task automatic t_irq();
    // bit 27 is open under the reset normal mask
    @(negedge clk); evt_norm_i = 32'h0800_0000;
    @(negedge clk); evt_norm_i = '0;
    chk("R6 irq one cycle late", 32'(irq_o), 0);
    @(negedge clk);
    chk("R6 irq rises", 32'(irq_o), 1);
    wr(A_NSTAT, 32'h0800_0000);
    chk("R6 irq still high", 32'(irq_o), 1);
    @(negedge clk);
    chk("R6 irq falls", 32'(irq_o), 0);
    wr(A_EEN, 32'h0000_0020);
    pulse('0, 32'h0000_0020);
    @(negedge clk);
    chk("R6 err irq", 32'(irq_o), 1);
    wr(A_EDIS, 32'h0000_0020);
    @(negedge clk);
    chk("R6 remask drops irq", 32'(irq_o), 0);
    wr(A_ESTAT, 32'h0000_0020);
  endtask

  task automatic t_gcmd();
    logic [31:0] v;
    wr(A_GCMD, 32'hABCD_E123);
    rd(A_GCMD, v); chk("R7 reads zero", v, 0);
    chk("R7 low 12 kept", 32'(gcmd_o), 32'h123);
  endtask

  task automatic t_chan();
    logic [31:0] v;
    wr(cha(0, 0), 32'hFFFF_FFFF);
    rd(cha(0, 0), v); chk("R8 ctrl 30 bits", v, 32'h3FFF_FFFF);
    wr(cha(5, 8), 32'h1234_5678);
    rd(cha(5, 8), v); chk("R8 ext 16 bits", v, 32'h0000_5678);
    wr(cha(5, 4), 32'hDEAD_BEEF);
    rd(cha(5, 4), v); chk("R8 start full", v, 32'hDEAD_BEEF);
    rd(cha(3, 0), v); chk("R8 other channel", v, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    pulse(32'h0000_0600, '0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_NSTAT; reg_wdata = 32'h0000_0600; evt_norm_i = 32'h0000_0200;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_norm_i = '0;
    rd(A_NSTAT, v); chk("R9 set beats clear", v, 32'h0000_0200);
    wr(A_NSTAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_unaligned();
    logic [31:0] v;
    wr(12'h00A, 32'hFFFF_FFFF);
    rd(A_NMASK, v); chk("R10 misaligned write", v, 32'h07FF_FFFF);
    wr(cha(0, 1), 32'h0);
    rd(cha(0, 0), v); chk("R10 ch ctrl kept", v, 32'h3FFF_FFFF);
    rd(12'h005, v); chk("R10 misaligned read", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_norm_i = '0; evt_err_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_w1c();
    t_mask();
    t_ro();
    t_irq();
    t_gcmd();
    t_chan();
    t_set_wins();
    t_unaligned();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule